// File: doc/BRIEF.md
# Station Address Bank with Clock-Crossing Update

This block stores a small set of 48-bit station addresses. A host writes them over a plain 32-bit register bus in its own clock domain, and receive-path logic reads them in a separate line clock domain. Each entry occupies two words: an upper word that carries bits 47:32 of the address in its lower 16 bits, and a lower word that carries bits 31:0.

Host writes update only a host-side shadow copy. One byte lane of the lower word acts as a commit lane. In little-endian mode it is the most significant lane, and in big-endian mode it is the least significant lane. When a write covers that lane, the full 48-bit shadow value is captured into a hold register, including the bytes carried by that same write. A toggle flag then tells the line domain to take the new value. The toggle passes through a two-stage synchronizer, and its edge loads all 48 bits into the line-side copy in one cycle. Because of this, the receive logic never sees an address made of two different updates.

Software must leave at least four line clock cycles between commits to the same entry. Reads return the shadow values.

Top module: `addr_xfer_bank`

## Requirements
- R1: Entry i occupies word address 2i (upper word, bits [15:0] = address bits 47:32) and word address 2i+1 (lower word = address bits 31:0). A read of word address a returns the shadow value combinationally. The upper word reads with bits [31:16] as zero.
- R2: Write byte enable bit k updates bits [8k+7:8k] of the addressed word, and lanes whose enable is clear keep their value. For the upper word, only enable bits 1 and 0 have any effect.
- R3: A write to an upper word, or a lower-word write that does not cover the commit lane, leaves the line-side copy of every entry unchanged.
- R4: When big_endian is 0, a lower-word write with enable bit 3 set commits the entry.
- R5: When big_endian is 1, a lower-word write with enable bit 0 set commits the entry. A write with only bit 3 set does not commit.
- R6: A commit transfers the full 48-bit shadow value, including the bytes of the committing write. The line copy still shows the old value right after the committing host edge, and shows the new value by the fourth rising line clock edge after it.
- R7: The line-side copy of an entry only ever takes a complete captured value, never a mixture of two updates. This holds when commits are spaced at least four line clocks apart.
- R8: After reset, every shadow word and every line-side address is all ones.
- R9: A commit of one entry leaves the line-side copies of all other entries unchanged.
- R10: The line-side copy of entry i appears on line_addr[48i+47:48i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host clock |
| hrst_n | input | 1 | Host-domain asynchronous active-low reset |
| big_endian | input | 1 | Selects the commit lane: 0 selects lane 3, 1 selects lane 0 |
| wr_en | input | 1 | Write strobe, sampled on hclk |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables of the write |
| rd_addr | input | AW | Word address of the read |
| rd_data | output | 32 | Read data (shadow value) |
| lclk | input | 1 | Line clock |
| lrst_n | input | 1 | Line-domain asynchronous active-low reset |
| line_addr | output | 48*NUM_ENTRIES | Line-side copies of all entries |

## Verification
Two operations can land on the same host edge: the shadow update of a write and the commit capture it triggers. A full-word lower write that carries the commit lane provokes this case. The test judges it by whether the line copy ends up holding the bytes of that same write rather than the older shadow contents. In the line domain, a commit load may also coincide with a quiet entry. This is judged by checking that the other entries' line copies stay unchanged after each commit.

// File: rtl/addr_bank_pkg.sv
package addr_bank_pkg;
  localparam int STN_W  = 48;
  localparam int HI_W   = 16;
  localparam int LO_W   = 32;
  localparam int BUS_W  = 32;
  localparam int LANES  = BUS_W / 8;
  localparam int HI_LANES = HI_W / 8;

  // commit lane index selected by the endianness setting
  function automatic logic [1:0] commit_lane(input logic big_endian);
    return big_endian ? 2'd0 : 2'(LANES - 1);
  endfunction
endpackage

// File: rtl/addr_rst_sync.sv
module addr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/addr_host_regs.sv
module addr_host_regs
  import addr_bank_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int AW = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         big_endian,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [BUS_W-1:0]             wr_data,
  input  logic [LANES-1:0]             wr_be,
  input  logic [AW-1:0]                rd_addr,
  output logic [BUS_W-1:0]             rd_data,
  output logic [NUM_ENTRIES*STN_W-1:0] hold_flat,
  output logic [NUM_ENTRIES-1:0]       tog
);
  logic [NUM_ENTRIES-1:0][HI_W-1:0] hi_vis;
  logic [NUM_ENTRIES-1:0][LO_W-1:0] lo_vis;
  logic [1:0] lane;

  always_comb lane = commit_lane(big_endian);

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    localparam logic [AW-1:0] HI_IDX = AW'(2 * i);
    localparam logic [AW-1:0] LO_IDX = AW'(2 * i + 1);

    logic [HI_W-1:0]  hi_q, hi_d;
    logic [LO_W-1:0]  lo_q, lo_d;
    logic [STN_W-1:0] hold_q, hold_d;
    logic             tog_q, tog_d;
    logic             sel_hi, sel_lo, commit;

    always_comb begin
      sel_hi = wr_en && (wr_addr == HI_IDX);
      sel_lo = wr_en && (wr_addr == LO_IDX);
      hi_d = hi_q;
      lo_d = lo_q;
      for (int b = 0; b < HI_LANES; b++)
        if (sel_hi && wr_be[b]) hi_d[8*b +: 8] = wr_data[8*b +: 8];
      for (int b = 0; b < LANES; b++)
        if (sel_lo && wr_be[b]) lo_d[8*b +: 8] = wr_data[8*b +: 8];
      commit = sel_lo && wr_be[lane];
      hold_d = commit ? {hi_d, lo_d} : hold_q;
      tog_d  = tog_q ^ commit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q   <= '1;
        lo_q   <= '1;
        hold_q <= '1;
        tog_q  <= 1'b0;
      end else begin
        hi_q   <= hi_d;
        lo_q   <= lo_d;
        hold_q <= hold_d;
        tog_q  <= tog_d;
      end
    end

    assign hi_vis[i] = hi_q;
    assign lo_vis[i] = lo_q;
    assign hold_flat[STN_W*i +: STN_W] = hold_q;
    assign tog[i] = tog_q;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_ENTRIES; k++) begin
      if (rd_addr == AW'(2 * k))     rd_data = {{(BUS_W-HI_W){1'b0}}, hi_vis[k]};
      if (rd_addr == AW'(2 * k + 1)) rd_data = lo_vis[k];
    end
  end
endmodule

// File: rtl/addr_line_copy.sv
module addr_line_copy
  import addr_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tog_in,
  input  logic [STN_W-1:0] hold_in,
  output logic [STN_W-1:0] line_q
);
  logic s1_q, s2_q, s3_q;
  logic load;
  logic [STN_W-1:0] line_d;

  always_comb begin
    load   = s2_q ^ s3_q;
    line_d = load ? hold_in : line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      line_q <= '1;
    end else begin
      s1_q   <= tog_in;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      line_q <= line_d;
    end
  end
endmodule

// File: rtl/addr_xfer_bank.sv
module addr_xfer_bank
  import addr_bank_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int AW = $clog2(2 * NUM_ENTRIES)
) (
  input  logic                         hclk,
  input  logic                         hrst_n,
  input  logic                         big_endian,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [BUS_W-1:0]             wr_data,
  input  logic [LANES-1:0]             wr_be,
  input  logic [AW-1:0]                rd_addr,
  output logic [BUS_W-1:0]             rd_data,
  input  logic                         lclk,
  input  logic                         lrst_n,
  output logic [NUM_ENTRIES*STN_W-1:0] line_addr
);
  logic                         host_rst_n;
  logic                         line_rst_n;
  logic [NUM_ENTRIES*STN_W-1:0] hold_flat;
  logic [NUM_ENTRIES-1:0]       tog;

  addr_rst_sync #(.STAGES(2)) u_hrst (.clk(hclk), .arst_n(hrst_n), .srst_n(host_rst_n));
  addr_rst_sync #(.STAGES(2)) u_lrst (.clk(lclk), .arst_n(lrst_n), .srst_n(line_rst_n));

  addr_host_regs #(.NUM_ENTRIES(NUM_ENTRIES), .AW(AW)) u_host (
    .clk(hclk), .rst_n(host_rst_n), .big_endian(big_endian),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .rd_addr(rd_addr), .rd_data(rd_data), .hold_flat(hold_flat), .tog(tog)
  );

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_line
    addr_line_copy u_copy (
      .clk(lclk), .rst_n(line_rst_n), .tog_in(tog[i]),
      .hold_in(hold_flat[STN_W*i +: STN_W]),
      .line_q(line_addr[STN_W*i +: STN_W])
    );
  end
endmodule

// File: rtl/addr_bank_chk.sv
module addr_bank_chk #(
  parameter int NUM_ENTRIES = 4,
  parameter int AW = 3
) (
  input logic                      hclk,
  input logic                      host_rst_n,
  input logic                      lclk,
  input logic                      line_rst_n,
  input logic                      big_endian,
  input logic                      wr_en,
  input logic [AW-1:0]             wr_addr,
  input logic [3:0]                wr_be,
  input logic [AW-1:0]             rd_addr,
  input logic [31:0]               rd_data,
  input logic [NUM_ENTRIES-1:0]    tog,
  input logic [NUM_ENTRIES*48-1:0] hold_flat,
  input logic [NUM_ENTRIES*48-1:0] line_addr
);
  // R1: upper word reads zero in its unused half
  p_hi_read_zero_r1: assert property (@(posedge hclk) disable iff (!host_rst_n)
    (!rd_addr[0] && (int'(rd_addr) < 2 * NUM_ENTRIES)) |-> (rd_data[31:16] == 16'h0));

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_chk
    localparam logic [AW-1:0] HI_IDX = AW'(2 * i);
    localparam logic [AW-1:0] LO_IDX = AW'(2 * i + 1);

    // R3: upper-word writes never start a transfer
    p_hi_quiet_r3: assert property (@(posedge hclk) disable iff (!host_rst_n)
      (wr_en && wr_addr == HI_IDX) |=> (tog[i] == $past(tog[i])));

    // R4: little-endian commit lane flips the toggle
    p_le_commit_r4: assert property (@(posedge hclk) disable iff (!host_rst_n)
      (wr_en && wr_addr == LO_IDX && !big_endian && wr_be[3]) |=> (tog[i] != $past(tog[i])));

    // R5: big-endian commit lane flips the toggle, lane 3 alone does not
    p_be_commit_r5: assert property (@(posedge hclk) disable iff (!host_rst_n)
      (wr_en && wr_addr == LO_IDX && big_endian && wr_be[0]) |=> (tog[i] != $past(tog[i])));
    p_be_nolane3_r5: assert property (@(posedge hclk) disable iff (!host_rst_n)
      (wr_en && wr_addr == LO_IDX && big_endian && !wr_be[0]) |=> $stable(tog[i]));

    // R6: the captured value stays put while no transfer is announced
    p_hold_stable_r6: assert property (@(posedge hclk) disable iff (!host_rst_n)
      $stable(tog[i]) |-> $stable(hold_flat[48*i +: 48]));

    // R7: the line copy only ever changes to a complete captured value
    p_whole_load_r7: assert property (@(posedge lclk) disable iff (!line_rst_n)
      (line_addr[48*i +: 48] != $past(line_addr[48*i +: 48])) |->
      (line_addr[48*i +: 48] == hold_flat[48*i +: 48]));
  end
endmodule

bind addr_xfer_bank addr_bank_chk #(.NUM_ENTRIES(NUM_ENTRIES), .AW(AW)) u_chk (
  .hclk(hclk), .host_rst_n(host_rst_n), .lclk(lclk), .line_rst_n(line_rst_n),
  .big_endian(big_endian), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
  .rd_addr(rd_addr), .rd_data(rd_data), .tog(tog), .hold_flat(hold_flat),
  .line_addr(line_addr)
);

// File: tb/addr_xfer_bank_tb.sv
module addr_xfer_bank_tb;
  localparam int N  = 4;
  localparam int AW = 3;

  logic          hclk = 1'b0, lclk = 1'b0;
  logic          hrst_n, lrst_n;
  logic          big_endian, wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [31:0]   wr_data, rd_data;
  logic [3:0]    wr_be;
  logic [N*48-1:0] line_addr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 hclk = ~hclk;
  always #3.5 lclk = ~lclk;

  addr_xfer_bank #(.NUM_ENTRIES(N)) u_dut (
    .hclk(hclk), .hrst_n(hrst_n), .big_endian(big_endian), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .rd_addr(rd_addr),
    .rd_data(rd_data), .lclk(lclk), .lrst_n(lrst_n), .line_addr(line_addr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input int a, input logic [31:0] d, input logic [3:0] be);
    @(negedge hclk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; wr_be = be;
    @(negedge hclk);
    wr_en = 1'b0;
  endtask

  task automatic read_check(input string req, input int a, input logic [31:0] exp);
    rd_addr = AW'(a);
    #1;
    check(req, {32'h0, rd_data}, {32'h0, exp});
  endtask

  task automatic line_check(input string req, input int e, input logic [47:0] exp);
    check(req, {16'h0, line_addr[48*e +: 48]}, {16'h0, exp});
  endtask

  task automatic wait_line(input int n);
    repeat (n) @(posedge lclk);
    #1;
  endtask

  task automatic t_reset;
    for (int e = 0; e < N; e++) begin
      read_check("R8 hi reset", 2*e, 32'h0000_FFFF);
      read_check("R8 lo reset", 2*e+1, 32'hFFFF_FFFF);
      line_check("R8 line reset", e, 48'hFFFF_FFFF_FFFF);
    end
  endtask

  task automatic t_shadow_only;
    big_endian = 1'b0;
    host_write(0, 32'h0000_1234, 4'b0011);
    host_write(1, 32'h00AB_CDEF, 4'b0111);
    read_check("R1 hi read", 0, 32'h0000_1234);
    read_check("R2 lo partial", 1, 32'hFFAB_CDEF);
    wait_line(6);
    line_check("R3 no commit", 0, 48'hFFFF_FFFF_FFFF);
  endtask

  task automatic t_le_commit;
    host_write(1, 32'h5A00_0000, 4'b1000);
    line_check("R6 old right after", 0, 48'hFFFF_FFFF_FFFF);
    wait_line(5);
    line_check("R4 le commit", 0, 48'h1234_5AAB_CDEF);
    line_check("R9 entry1 untouched", 1, 48'hFFFF_FFFF_FFFF);
  endtask

  task automatic t_be_commit;
    big_endian = 1'b1;
    host_write(2, 32'h0000_BEEF, 4'b1111);
    host_write(3, 32'h1100_0000, 4'b1000);
    wait_line(6);
    line_check("R5 lane3 no commit", 1, 48'hFFFF_FFFF_FFFF);
    host_write(3, 32'h0000_0022, 4'b0001);
    wait_line(5);
    line_check("R5 be commit", 1, 48'hBEEF_11FF_FF22);
    line_check("R9 entry0 kept", 0, 48'h1234_5AAB_CDEF);
    big_endian = 1'b0;
  endtask

  task automatic t_same_edge;
    host_write(5, 32'hCAFE_F00D, 4'b1111);
    wait_line(5);
    line_check("R6 same-write bytes", 2, 48'hFFFF_CAFE_F00D);
    line_check("R10 slice entry1", 1, 48'hBEEF_11FF_FF22);
  endtask

  task automatic t_hi_lanes;
    host_write(6, 32'h0000_AA00, 4'b0010);
    read_check("R2 hi lane1", 6, 32'h0000_AAFF);
    host_write(6, 32'hFFFF_1357, 4'b1111);
    read_check("R1 hi upper zero", 6, 32'h0000_1357);
    wait_line(6);
    line_check("R3 hi no commit", 3, 48'hFFFF_FFFF_FFFF);
  endtask

  task automatic t_spaced;
    host_write(1, 32'h0100_0000, 4'b1000);
    wait_line(6);
    line_check("R7 first update", 0, 48'h1234_01AB_CDEF);
    host_write(1, 32'h0200_0000, 4'b1000);
    wait_line(6);
    line_check("R7 second update", 0, 48'h1234_02AB_CDEF);
    line_check("R9 entry2 kept", 2, 48'hFFFF_CAFE_F00D);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    hrst_n = 1'b0; lrst_n = 1'b0;
    big_endian = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_be = '0; rd_addr = '0;
    #33;
    hrst_n = 1'b1; lrst_n = 1'b1;
    repeat (5) @(negedge hclk);
    t_reset;
    t_shadow_only;
    t_le_commit;
    t_be_commit;
    t_same_edge;
    t_hi_lanes;
    t_spaced;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule